// File: doc/BRIEF.md
# Console Storage Port Registers

This block gives software two byte-wide console storage channels on a small register bus: an inbound channel that captures bytes arriving from an external source, and an outbound channel that hands bytes to an external sink. Each channel has a status word with a ready flag (DONE) and an interrupt enable (IE), plus a data register. Each channel drives its own level interrupt request. The request follows DONE and IE: it rises when a byte lands or a transmission completes with IE set, and it also rises at once when software sets IE on a channel that is already done.

Inbound bytes arrive on a valid/ready stream. `rx_ready` is tied high, so the source is never back-pressured. Every beat with `rx_valid` high is taken, and it overwrites the byte held before. Outbound bytes leave on a valid/ready stream. A write to the outbound data register raises `tx_valid` with the byte on `tx_data`. Both stay fixed until the sink accepts them with `tx_ready`, so a slow sink simply lengthens the busy period. The handshake is what completes the transfer. Bus reads are combinational on `bus_addr`, and any side effect of a read or write takes hold at the clock edge where `bus_rd` or `bus_wr` is high.

Register offsets (`bus_addr`): 0 inbound status, 1 inbound data, 2 outbound status, 3 outbound data.

Top module: `csp_regs`

## Requirements
- R1: A status word reads DONE at bit 7 and IE at bit 6, and every other bit reads 0. A status write changes only IE, taken from `bus_wdata` bit 6. DONE cannot be written.
- R2: After reset the inbound status reads 0x00, the inbound data reads 0x00, the outbound status reads 0x80 (DONE set), and both interrupt requests and `tx_valid` are low.
- R3: An `rx_valid` beat loads `rx_data` into the inbound buffer and sets inbound DONE. If IE is set, `irq_rx` is high from the next cycle.
- R4: Reading inbound data returns the buffered byte zero-extended. The read clears inbound DONE and drops `irq_rx` at that edge.
- R5: A status write with bit 6 clear drops that channel's interrupt request at that edge.
- R6: A status write with bit 6 set, on a channel whose DONE is set and whose IE was clear, raises its interrupt request at that edge. With DONE clear, the request stays low.
- R7: Writing outbound data takes `bus_wdata[7:0]`, clears outbound DONE, drops `irq_tx` and raises `tx_valid` with that byte on `tx_data`. Both stay unchanged until `tx_ready`.
- R8: A cycle with `tx_valid` and `tx_ready` both high ends the transfer. `tx_valid` falls, outbound DONE sets, and `irq_tx` rises if IE is set.
- R9: Reading outbound data returns 0. Writing inbound data changes neither the buffer nor inbound DONE.
- R10: An `rx_valid` beat in the same cycle as an inbound data read leaves DONE set, holding the new byte; the read returns the old one. An outbound data write in the same cycle as a sink handshake starts the new transfer and leaves DONE clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on bus_addr |
| rx_valid | input | 1 | Inbound byte present |
| rx_data | input | BYTE_W | Inbound byte |
| rx_ready | output | 1 | Always high: inbound never stalls |
| tx_valid | output | 1 | Outbound byte pending |
| tx_data | output | BYTE_W | Outbound byte |
| tx_ready | input | 1 | Sink accepts outbound byte |
| irq_rx | output | 1 | Inbound interrupt request |
| irq_tx | output | 1 | Outbound interrupt request |

## Verification
DONE and IE are visible on the very next status read, and the interrupt pins register their change at the same edge as the causing access. A corrupted flag therefore shows up one cycle after the event, either as a wrong `irq_*` level or as a wrong status word. A stale or mis-captured byte shows on the following inbound data read or on `tx_data` as soon as `tx_valid` rises. A transfer that never finishes shows as `tx_valid` still high one cycle after a handshake, with DONE still clear.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int CSP_DONE_BIT = 7;
  localparam int CSP_IE_BIT   = 6;
  localparam int CH_IN        = 0;
  localparam int CH_OUT       = 1;
  localparam int CH_NUM       = 2;

  typedef enum logic [1:0] {
    REG_IN_STAT  = 2'd0,
    REG_IN_DATA  = 2'd1,
    REG_OUT_STAT = 2'd2,
    REG_OUT_DATA = 2'd3
  } csp_reg_e;

  // inbound starts empty, outbound starts ready for a byte
  function automatic logic done_at_reset(input int ch);
    return (ch == CH_OUT);
  endfunction
endpackage

// File: rtl/csp_chan.sv
module csp_chan #(
  parameter bit DONE_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic wr_ie,
  input  logic set_done,
  input  logic clr_done,
  output logic done,
  output logic ie,
  output logic irq
);
  logic ie_n;
  logic done_n;
  logic irq_n;

  always_comb begin
    ie_n   = stat_wr ? wr_ie : ie;
    done_n = done;
    if (set_done)      done_n = 1'b1;
    else if (clr_done) done_n = 1'b0;

    irq_n = irq;
    if (set_done && ie_n)                 irq_n = 1'b1;
    else if (clr_done)                    irq_n = 1'b0;
    else if (stat_wr && !wr_ie)           irq_n = 1'b0;
    else if (stat_wr && wr_ie && done && !ie) irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= DONE_INIT;
      ie   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      done <= done_n;
      ie   <= ie_n;
      irq  <= irq_n;
    end
  end
endmodule

// File: rtl/csp_rx_buf.sv
module csp_rx_buf #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/csp_tx_port.sv
module csp_tx_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] din,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              complete
);
  // a fresh start in the same cycle supersedes the handshake
  assign complete = tx_valid && tx_ready && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (start) begin
      tx_valid <= 1'b1;
      tx_data  <= din;
    end else if (complete) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csp_regs.sv
module csp_regs
  import csp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam int EXT_W = DATA_W - BYTE_W;

  logic              wr_in_stat, wr_out_stat, wr_out_data, rd_in_data;
  logic              tx_complete;
  logic [BYTE_W-1:0] rx_byte;
  logic [CH_NUM-1:0] stat_wr, set_done, clr_done;
  logic [CH_NUM-1:0] chan_done, chan_ie, chan_irq;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:BYTE_W];

  assign wr_in_stat  = bus_wr && (bus_addr == REG_IN_STAT);
  assign wr_out_stat = bus_wr && (bus_addr == REG_OUT_STAT);
  assign wr_out_data = bus_wr && (bus_addr == REG_OUT_DATA);
  assign rd_in_data  = bus_rd && (bus_addr == REG_IN_DATA);
  // writes to inbound data and reads of outbound data have no side effect

  assign rx_ready = 1'b1;

  assign stat_wr[CH_IN]   = wr_in_stat;
  assign stat_wr[CH_OUT]  = wr_out_stat;
  assign set_done[CH_IN]  = rx_valid;
  assign set_done[CH_OUT] = tx_complete;
  assign clr_done[CH_IN]  = rd_in_data;
  assign clr_done[CH_OUT] = wr_out_data;

  for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
    csp_chan #(.DONE_INIT(done_at_reset(g))) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_wr  (stat_wr[g]),
      .wr_ie    (bus_wdata[CSP_IE_BIT]),
      .set_done (set_done[g]),
      .clr_done (clr_done[g]),
      .done     (chan_done[g]),
      .ie       (chan_ie[g]),
      .irq      (chan_irq[g])
    );
  end

  assign irq_rx = chan_irq[CH_IN];
  assign irq_tx = chan_irq[CH_OUT];

  csp_rx_buf #(.BYTE_W(BYTE_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rx_valid),
    .din   (rx_data),
    .dout  (rx_byte)
  );

  csp_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (wr_out_data),
    .din      (bus_wdata[BYTE_W-1:0]),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .complete (tx_complete)
  );

  always_comb begin
    bus_rdata = '0;
    case (csp_reg_e'(bus_addr))
      REG_IN_STAT: begin
        bus_rdata[CSP_DONE_BIT] = chan_done[CH_IN];
        bus_rdata[CSP_IE_BIT]   = chan_ie[CH_IN];
      end
      REG_IN_DATA:  bus_rdata = {{EXT_W{1'b0}}, rx_byte};
      REG_OUT_STAT: begin
        bus_rdata[CSP_DONE_BIT] = chan_done[CH_OUT];
        bus_rdata[CSP_IE_BIT]   = chan_ie[CH_OUT];
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/csp_regs_chk.sv
module csp_regs_chk
  import csp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic              wdata_ie,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic [1:0]        chan_done,
  input logic [1:0]        chan_ie
);
  localparam logic [DATA_W-1:0] STAT_MASK =
    (DATA_W'(1) << CSP_DONE_BIT) | (DATA_W'(1) << CSP_IE_BIT);

  logic is_stat, rd_in, wr_in, wr_out;
  assign is_stat = (bus_addr == REG_IN_STAT) || (bus_addr == REG_OUT_STAT);
  assign rd_in   = bus_rd && (bus_addr == REG_IN_DATA);
  assign wr_in   = bus_wr && (bus_addr == REG_IN_DATA);
  assign wr_out  = bus_wr && (bus_addr == REG_OUT_DATA);

  assert_stat_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_stat |-> ((bus_rdata & ~STAT_MASK) == '0));

  assert_rx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> chan_done[0]);

  assert_rd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && !rx_valid) |=> (!irq_rx && !chan_done[0]));

  assert_ie_off_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_IN_STAT && !wdata_ie) |=> !irq_rx);

  assert_ie_off_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_OUT_STAT && !wdata_ie) |=> !irq_tx);

  assert_irq_rx_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == (chan_done[0] && chan_ie[0]));

  assert_irq_tx_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx == (chan_done[1] && chan_ie[1]));

  assert_tx_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> (tx_valid && !chan_done[1] && !irq_tx));

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_out) |=> (tx_valid && $stable(tx_data)));

  assert_tx_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !wr_out) |=> (!tx_valid && chan_done[1]));

  assert_out_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_OUT_DATA) |-> (bus_rdata == '0));

  assert_in_data_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && !bus_rd && !rx_valid) |=> $stable(chan_done[0]));

  assert_rx_over_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rd_in) |=> chan_done[0]);
endmodule

bind csp_regs csp_regs_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .wdata_ie  (bus_wdata[csp_pkg::CSP_IE_BIT]),
  .bus_rdata (bus_rdata),
  .rx_valid  (rx_valid),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .irq_rx    (irq_rx),
  .irq_tx    (irq_tx),
  .chan_done (chan_done),
  .chan_ie   (chan_ie)
);

// File: tb/csp_regs_test.sv
module csp_regs_test;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]        bus_addr = 2'd0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              rx_valid = 1'b0;
  logic [BYTE_W-1:0] rx_data = '0;
  logic              rx_ready;
  logic              tx_valid;
  logic [BYTE_W-1:0] tx_data;
  logic              tx_ready = 1'b0;
  logic              irq_rx, irq_tx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  csp_regs #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // one bus/stream cycle; q is bus_rdata sampled before the edge
  task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [DATA_W-1:0] wd, input logic rv,
                      input logic [BYTE_W-1:0] rb, input logic tr,
                      output logic [DATA_W-1:0] q);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_data = rb; tx_ready = tr;
    #1 q = bus_rdata;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] q;
    step(1'b1, 1'b0, a, d, 1'b0, '0, 1'b0, q);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [DATA_W-1:0] q);
    step(1'b0, 1'b1, a, '0, 1'b0, '0, 1'b0, q);
  endtask

  task automatic rx_byte(input logic [BYTE_W-1:0] b);
    logic [DATA_W-1:0] q;
    step(1'b0, 1'b0, 2'd0, '0, 1'b1, b, 1'b0, q);
  endtask

  task automatic idle(input logic tr);
    logic [DATA_W-1:0] q;
    step(1'b0, 1'b0, 2'd0, '0, 1'b0, '0, tr, q);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 reset state
    chk("R2 irq_rx", DATA_W'(irq_rx), 0);
    chk("R2 irq_tx", DATA_W'(irq_tx), 0);
    chk("R2 tx_valid", DATA_W'(tx_valid), 0);
    chk("R2 rx_ready", DATA_W'(rx_ready), 1);
    rd_reg(2'd0, q); chk("R2 in status", q, 16'h0000);
    rd_reg(2'd2, q); chk("R2 out status", q, 16'h0080);
    rd_reg(2'd1, q); chk("R2 in data", q, 16'h0000);

    // R1 only IE writable, padding zero; R6/R5 on outbound (done at reset)
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, q); chk("R1 in status all-ones write", q, 16'h0040);
    chk("R6 no irq_rx without DONE", DATA_W'(irq_rx), 0);
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd0, q); chk("R1 in status zero write", q, 16'h0000);
    wr_reg(2'd2, 16'hFFBF | 16'h0040);
    chk("R6 irq_tx on IE set while done", DATA_W'(irq_tx), 1);
    rd_reg(2'd2, q); chk("R1 out status", q, 16'h00C0);
    wr_reg(2'd2, 16'hFFBF);
    chk("R5 irq_tx dropped", DATA_W'(irq_tx), 0);
    rd_reg(2'd2, q); chk("R1 out status DONE kept", q, 16'h0080);

    // R3/R4 sweep over every byte value, IE alternating
    for (int b = 0; b < 256; b++) begin
      logic iev;
      iev = b[0];
      wr_reg(2'd0, DATA_W'(iev) << 6);
      rx_byte(BYTE_W'(b));
      chk("R3 irq_rx after byte", DATA_W'(irq_rx), DATA_W'(iev));
      rd_reg(2'd0, q); chk("R3 in status done", q, 16'h0080 | (DATA_W'(iev) << 6));
      rd_reg(2'd1, q); chk("R4 in data value", q, DATA_W'(b));
      chk("R4 irq_rx cleared", DATA_W'(irq_rx), 0);
      rd_reg(2'd0, q); chk("R4 in status cleared", q, DATA_W'(iev) << 6);
    end

    // R5/R6 sweep over prior IE, prior DONE and written IE
    for (int k = 0; k < 8; k++) begin
      logic ie0, dn0, wie;
      ie0 = k[0]; dn0 = k[1]; wie = k[2];
      wr_reg(2'd0, 16'h0000);
      rd_reg(2'd1, q);
      if (dn0) rx_byte(8'h5A);
      wr_reg(2'd0, DATA_W'(ie0) << 6);
      chk("R6 irq_rx precondition", DATA_W'(irq_rx), DATA_W'(dn0 & ie0));
      wr_reg(2'd0, DATA_W'(wie) << 6);
      chk(wie ? "R6 irq_rx after IE write" : "R5 irq_rx after IE clear",
          DATA_W'(irq_rx), DATA_W'(dn0 & wie));
    end

    // R7/R8 sweep over every byte, sink latency 0..3, IE alternating
    for (int b = 0; b < 256; b++) begin
      logic iev;
      int lat;
      iev = b[1];
      lat = b % 4;
      wr_reg(2'd2, DATA_W'(iev) << 6);
      wr_reg(2'd3, 16'hAB00 | DATA_W'(b));
      chk("R7 tx_valid", DATA_W'(tx_valid), 1);
      chk("R7 tx_data", DATA_W'(tx_data), DATA_W'(b));
      chk("R7 irq_tx low", DATA_W'(irq_tx), 0);
      for (int w = 0; w < lat; w++) idle(1'b0);
      chk("R7 tx_valid held", DATA_W'(tx_valid), 1);
      chk("R7 tx_data held", DATA_W'(tx_data), DATA_W'(b));
      rd_reg(2'd2, q); chk("R7 out status busy", q, DATA_W'(iev) << 6);
      idle(1'b1);
      chk("R8 tx_valid dropped", DATA_W'(tx_valid), 0);
      chk("R8 irq_tx", DATA_W'(irq_tx), DATA_W'(iev));
      rd_reg(2'd2, q); chk("R8 out status done", q, 16'h0080 | (DATA_W'(iev) << 6));
      rd_reg(2'd3, q); chk("R9 out data reads zero", q, 16'h0000);
    end

    // R9 inbound data write ignored
    wr_reg(2'd0, 16'h0000);
    rx_byte(8'hA3);
    wr_reg(2'd1, 16'h0055);
    rd_reg(2'd0, q); chk("R9 in status after data write", q, 16'h0080);
    rd_reg(2'd1, q); chk("R9 in data after data write", q, 16'h00A3);

    // R10 inbound: arrival beats a simultaneous read
    rx_byte(8'h11);
    step(1'b0, 1'b1, 2'd1, '0, 1'b1, 8'h22, 1'b0, q);
    chk("R10 read returns old byte", q, 16'h0011);
    rd_reg(2'd0, q); chk("R10 in done kept", q, 16'h0080);
    rd_reg(2'd1, q); chk("R10 new byte held", q, 16'h0022);

    // R10 outbound: new write beats a simultaneous handshake
    wr_reg(2'd2, 16'h0040);
    wr_reg(2'd3, 16'h0033);
    step(1'b1, 1'b0, 2'd3, 16'h0044, 1'b0, '0, 1'b1, q);
    chk("R10 tx_valid after overlap", DATA_W'(tx_valid), 1);
    chk("R10 tx_data after overlap", DATA_W'(tx_data), 16'h0044);
    chk("R10 irq_tx after overlap", DATA_W'(irq_tx), 0);
    rd_reg(2'd2, q); chk("R10 out status busy", q, 16'h0040);
    idle(1'b1);
    chk("R8 irq_tx after final handshake", DATA_W'(irq_tx), 1);

    summary();
    $finish;
  end
endmodule